// File: doc/BRIEF.md
# Precision Time-of-Day Counter

This block keeps a free-running time of day for a precision time protocol clock. The time has two parts: a 48-bit seconds count and a 30-bit nanoseconds count. The nanoseconds count rolls over at one billion. Each cycle of `clk` is one reference tick. On every tick the block adds a programmed step. The step has a whole-nanosecond part and a 24-bit sub-nanosecond fraction. The fraction builds up in its own accumulator, and each time that accumulator overflows it adds one more nanosecond to that tick.

Software reaches the block through a small register bus with 32-bit words. It can load seconds and nanoseconds, read the time back, and program the step. It can also apply a one-shot signed offset of less than one second. Some loads are staged so that a multi-word update lands in a single cycle:
- The upper seconds bits wait for a write of the lower seconds word.
- The fraction waits for a write of the whole-nanosecond step.

Reading the lower seconds word also captures the upper seconds in a shadow register. A later read of the upper word therefore belongs to the same instant.

The bus is a plain control interface, not a stream. Every access is accepted in the cycle it is presented, so there is no back-pressure. Read data appears one cycle after `rd_en`.

Top module: `tod_counter`

## Requirements
- R1: After reset, the seconds, nanoseconds, step (whole part and fraction), fraction accumulator, staged values and shadow are all zero.
- R2: On each cycle the nanoseconds count grows by the whole step plus the carry out of the 24-bit fraction accumulator. That accumulator adds the active fraction every cycle.
- R3: When the nanoseconds count would reach 1,000,000,000 or more, it wraps by that amount and the seconds count grows by one in the same cycle.
- R4: A write to address 1 stages bits 15:0 as seconds 47:32 and leaves the time unchanged. A write to address 0 loads seconds as {staged, wdata}. In that cycle the nanoseconds still advance, and their carry into seconds is dropped.
- R5: A write to address 2 loads nanoseconds from wdata[29:0] in place of that cycle's advance. The seconds count does not change in that cycle.
- R6: At address 4, bits 15:0 carry fraction bits 23:8 and bits 31:24 carry fraction bits 7:0. A write there is staged and has no effect on the active fraction. A write to address 3 sets the whole step from bits 7:0 and moves the staged fraction into use, both from the next cycle.
- R7: A write to address 5 applies an offset once, on top of that cycle's advance. The magnitude is in bits 29:0 and must be below one second. Bit 31 set means subtract. A result below zero borrows one second, and a result of one second or more carries one.
- R8: While the whole step and the fraction are both zero and no time write or offset occurs, the seconds and nanoseconds do not change.
- R9: Reading address 0 captures seconds 47:32 into a shadow register, and reading address 1 returns that shadow. The shadow changes on no other access.
- R10: When `rd_en` is high, `rdata` holds the addressed value from before that edge's update in the following cycle:
  - addresses 0 and 2 return the time fields;
  - addresses 3 and 4 return the active step in their write layouts;
  - every other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; each cycle is one tick |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |

## Verification
The hardest case to reach is a subtract offset that lands at the same instant as a nanosecond rollover or a fractional carry. That case exercises the carry and the borrow together in one cycle. The directed part loads the nanoseconds just below the rollover and then applies a large subtract and a large add. The random part mixes step changes, time loads and offsets of random sign with dense reads, and checks every read against a bench model of the requirements.

// File: rtl/tod_pkg.sv
package tod_pkg;
  typedef enum logic [2:0] {
    A_SEC_LO   = 3'd0,
    A_SEC_HI   = 3'd1,
    A_NSEC     = 3'd2,
    A_INC_NS   = 3'd3,
    A_INC_FRAC = 3'd4,
    A_ADJ      = 3'd5
  } tod_addr_e;

  localparam int unsigned NS_PER_SEC = 1000000000;
endpackage

// File: rtl/tod_step.sv
// Step generator: active increment, staged fraction, fraction accumulator.
module tod_step #(
  parameter int INC_NS_W = 8,
  parameter int FRAC_W   = 24,
  localparam int STEP_W  = INC_NS_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frac_wr,
  input  logic [FRAC_W-1:0]   frac_wdata,
  input  logic                whole_wr,
  input  logic [INC_NS_W-1:0] whole_wdata,
  output logic [STEP_W-1:0]   step,
  output logic [INC_NS_W-1:0] inc_ns_q,
  output logic [FRAC_W-1:0]   inc_frac_q
);
  logic [FRAC_W-1:0] frac_stage_q;
  logic [FRAC_W-1:0] frac_acc_q;
  logic [FRAC_W:0]   frac_sum;

  always_comb begin
    frac_sum = {1'b0, frac_acc_q} + {1'b0, inc_frac_q};
    step     = {1'b0, inc_ns_q} + STEP_W'(frac_sum[FRAC_W]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frac_stage_q <= '0;
      frac_acc_q   <= '0;
      inc_ns_q     <= '0;
      inc_frac_q   <= '0;
    end else begin
      frac_acc_q <= frac_sum[FRAC_W-1:0];
      if (frac_wr) frac_stage_q <= frac_wdata;
      if (whole_wr) begin
        inc_ns_q   <= whole_wdata;
        inc_frac_q <= frac_stage;
      end
    end
  end

  // staged value seen by a same-cycle whole write is the stored stage
  logic [FRAC_W-1:0] frac_stage;
  assign frac_stage = frac_stage_q;

  // R6: a lone fraction write never disturbs the active fraction
  p_frac_staged_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (frac_wr && !whole_wr) |=> $stable(inc_frac_q));
endmodule

// File: rtl/tod_time.sv
// Seconds / nanoseconds datapath with rollover, offset and loads.
module tod_time import tod_pkg::*; #(
  parameter int SEC_W  = 48,
  parameter int NS_W   = 30,
  parameter int STEP_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STEP_W-1:0] step,
  input  logic              sec_ld,
  input  logic [SEC_W-1:0]  sec_ld_val,
  input  logic              ns_ld,
  input  logic [NS_W-1:0]   ns_ld_val,
  input  logic              adj_en,
  input  logic              adj_sub,
  input  logic [NS_W-1:0]   adj_mag,
  output logic [SEC_W-1:0]  sec_q,
  output logic [NS_W-1:0]   ns_q
);
  localparam int ACC_W = NS_W + 2;
  localparam logic [ACC_W-1:0] NSPS = ACC_W'(NS_PER_SEC);
  localparam logic signed [ACC_W:0] NSPS_S = $signed({1'b0, NSPS});

  logic [ACC_W-1:0]      sum1, s1;
  logic                  wrap1, wrap2, borrow;
  logic signed [ACC_W:0] t, tfix;
  logic [NS_W-1:0]       ns_next;
  logic [SEC_W-1:0]      sec_next;

  always_comb begin
    sum1  = ACC_W'(ns_q) + ACC_W'(step);
    wrap1 = (sum1 >= NSPS);
    s1    = wrap1 ? (sum1 - NSPS) : sum1;
    if (!adj_en)      t = $signed({1'b0, s1});
    else if (adj_sub) t = $signed({1'b0, s1}) - $signed({1'b0, ACC_W'(adj_mag)});
    else              t = $signed({1'b0, s1}) + $signed({1'b0, ACC_W'(adj_mag)});
    borrow = (t < 0);
    wrap2  = (t >= NSPS_S);
    if (borrow)     tfix = t + NSPS_S;
    else if (wrap2) tfix = t - NSPS_S;
    else            tfix = t;
    ns_next  = tfix[NS_W-1:0];
    sec_next = sec_q + SEC_W'(wrap1) + SEC_W'(wrap2) - SEC_W'(borrow);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_q <= '0;
      ns_q  <= '0;
    end else begin
      ns_q <= ns_ld ? ns_ld_val : ns_next;
      if (sec_ld)      sec_q <= sec_ld_val;
      else if (!ns_ld) sec_q <= sec_next;
    end
  end

  // R3: free-running nanoseconds stay inside one second
  p_ns_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ns_ld && ns_q < NS_W'(NS_PER_SEC)) |=> (ns_q < NS_W'(NS_PER_SEC)));
  // R3: without loads or offsets seconds move by at most one
  p_sec_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_ld && !ns_ld && !adj_en) |=>
      (sec_q == $past(sec_q)) || (sec_q == $past(sec_q) + SEC_W'(1)));
  // R8: zero step and no writes freezes the time
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (step == '0 && !adj_en && !ns_ld && !sec_ld) |=> ($stable(ns_q) && $stable(sec_q)));
endmodule

// File: rtl/tod_counter.sv
module tod_counter import tod_pkg::*; #(
  parameter int SEC_W    = 48,
  parameter int NS_W     = 30,
  parameter int INC_NS_W = 8,
  parameter int DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int HI_W   = SEC_W - DATA_W;
  localparam int FRAC_W = 24;
  localparam int STEP_W = INC_NS_W + 1;

  logic wr_lo, wr_hi, wr_ns, wr_whole, wr_frac, wr_adj, rd_lo;
  logic [HI_W-1:0]     hi_stage_q, shadow_q;
  logic [STEP_W-1:0]   step;
  logic [INC_NS_W-1:0] inc_ns_q;
  logic [FRAC_W-1:0]   inc_frac_q, frac_in;
  logic [SEC_W-1:0]    sec_q;
  logic [NS_W-1:0]     ns_q;

  always_comb begin
    wr_lo    = wr_en && addr == A_SEC_LO;
    wr_hi    = wr_en && addr == A_SEC_HI;
    wr_ns    = wr_en && addr == A_NSEC;
    wr_whole = wr_en && addr == A_INC_NS;
    wr_frac  = wr_en && addr == A_INC_FRAC;
    wr_adj   = wr_en && addr == A_ADJ;
    rd_lo    = rd_en && addr == A_SEC_LO;
    frac_in  = {wdata[15:0], wdata[31:24]};
  end

  tod_step #(.INC_NS_W(INC_NS_W), .FRAC_W(FRAC_W)) u_step (
    .clk(clk), .rst_n(rst_n),
    .frac_wr(wr_frac), .frac_wdata(frac_in),
    .whole_wr(wr_whole), .whole_wdata(wdata[INC_NS_W-1:0]),
    .step(step), .inc_ns_q(inc_ns_q), .inc_frac_q(inc_frac_q)
  );

  tod_time #(.SEC_W(SEC_W), .NS_W(NS_W), .STEP_W(STEP_W)) u_time (
    .clk(clk), .rst_n(rst_n), .step(step),
    .sec_ld(wr_lo), .sec_ld_val({hi_stage_q, wdata}),
    .ns_ld(wr_ns), .ns_ld_val(wdata[NS_W-1:0]),
    .adj_en(wr_adj), .adj_sub(wdata[DATA_W-1]), .adj_mag(wdata[NS_W-1:0]),
    .sec_q(sec_q), .ns_q(ns_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_stage_q <= '0;
      shadow_q   <= '0;
      rdata      <= '0;
    end else begin
      if (wr_hi) hi_stage_q <= wdata[HI_W-1:0];
      if (rd_lo) shadow_q <= sec_q[SEC_W-1:DATA_W];
      if (rd_en) begin
        case (addr)
          A_SEC_LO:   rdata <= sec_q[DATA_W-1:0];
          A_SEC_HI:   rdata <= DATA_W'(shadow_q);
          A_NSEC:     rdata <= DATA_W'(ns_q);
          A_INC_NS:   rdata <= DATA_W'(inc_ns_q);
          A_INC_FRAC: rdata <= {inc_frac_q[7:0], 8'h00, inc_frac_q[23:8]};
          default:    rdata <= '0;
        endcase
      end
    end
  end

  // R9: shadow only moves on a low-seconds read
  p_shadow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_lo |=> $stable(shadow_q));
  // R4: a high-seconds write alone never loads the seconds count
  p_hi_staged_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && step == '0) |=> $stable(sec_q));
endmodule

// File: tb/tb_tod_counter.sv
module tb_tod_counter;
  localparam int CLK_PERIOD = 10;
  localparam longint NSPS = 1000000000;
  localparam longint SMASK = 64'hFFFF_FFFF_FFFF;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  tod_counter dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
                   .addr(addr), .wdata(wdata), .rdata(rdata));

  int checks = 0, errors = 0;
  bit done = 0;
  longint m_sec = 0, m_ns = 0, m_acc = 0, m_incns = 0, m_incfr = 0;
  longint m_fst = 0, m_hst = 0, m_shd = 0;
  logic [31:0] m_rd = '0;

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // bench model of the requirements, advanced once per clock edge
  task automatic model(input bit we, input bit re, input logic [2:0] a, input logic [31:0] d);
    longint fs, st, n, ds, mag;
    logic [23:0] fr;
    if (re) begin
      fr = 24'(m_incfr);
      case (a)
        3'd0: m_rd = 32'(m_sec);
        3'd1: m_rd = 32'(m_shd);
        3'd2: m_rd = 32'(m_ns);
        3'd3: m_rd = 32'(m_incns);
        3'd4: m_rd = {fr[7:0], 8'h00, fr[23:8]};
        default: m_rd = 32'h0;
      endcase
      if (a == 3'd0) m_shd = (m_sec >> 32) & 64'hFFFF;
    end
    fs = m_acc + m_incfr;
    st = m_incns + (fs >> 24);
    m_acc = fs & 64'hFF_FFFF;
    n = m_ns + st; ds = 0;
    if (n >= NSPS) begin n -= NSPS; ds = 1; end
    if (we && a == 3'd5) begin
      mag = longint'(d[29:0]);
      if (d[31]) n -= mag; else n += mag;
      if (n < 0) begin n += NSPS; ds -= 1; end
      else if (n >= NSPS) begin n -= NSPS; ds += 1; end
    end
    if (we && a == 3'd0) begin m_sec = (m_hst << 32) | longint'(d); m_ns = n; end
    else if (we && a == 3'd2) m_ns = longint'(d[29:0]);
    else begin m_sec = (m_sec + ds) & SMASK; m_ns = n; end
    if (we && a == 3'd1) m_hst = longint'(d[15:0]);
    if (we && a == 3'd3) begin m_incns = longint'(d[7:0]); m_incfr = m_fst; end
    if (we && a == 3'd4) m_fst = longint'({d[15:0], d[31:24]});
  endtask

  task automatic cyc(input bit we, input bit re, input logic [2:0] a,
                     input logic [31:0] d, input string tag);
    wr_en = we; rd_en = re; addr = a; wdata = d;
    @(posedge clk);
    model(we, re, a, d);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    if (re) check(rdata, m_rd, tag);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    cyc(1'b1, 1'b0, a, d, "");
  endtask
  task automatic rd(input logic [2:0] a, input string tag);
    cyc(1'b0, 1'b1, a, 32'h0, tag);
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 3'd0, 32'h0, "");
  endtask

  initial begin
    void'($urandom(32'd1588));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(3'd2, "R1 nsec"); check(rdata, 32'h0, "R1 nsec zero");
    rd(3'd0, "R1 sec lo"); rd(3'd3, "R1 inc");
    rd(3'd4, "R1 frac");
    idle(5);
    rd(3'd2, "R8 frozen after reset"); check(rdata, 32'h0, "R8 still zero");
    // R10 unmapped address
    rd(3'd6, "R10 unmapped"); check(rdata, 32'h0, "R10 unmapped zero");
    // R4 staged high seconds
    wr(3'd1, 32'h0000_1234);
    rd(3'd0, "R4 lo unchanged"); rd(3'd1, "R4 hi unchanged"); check(rdata, 32'h0, "R4 hi staged");
    wr(3'd0, 32'h89AB_CDEF);
    rd(3'd0, "R4 lo loaded"); rd(3'd1, "R9 shadow"); check(rdata, 32'h1234, "R9 shadow value");
    // R6 staged fraction then R2 half-ns fraction
    wr(3'd4, 32'h0000_8000);
    rd(3'd4, "R6 frac staged"); check(rdata, 32'h0, "R6 frac not active");
    wr(3'd3, 32'h0000_0000);
    rd(3'd4, "R6 frac layout"); check(rdata, 32'h0000_8000, "R6 frac active");
    idle(6);
    rd(3'd2, "R2 fractional step");
    wr(3'd4, 32'h5500_00AA); wr(3'd3, 32'h0000_0003);
    rd(3'd4, "R6 frac byte order"); check(rdata, 32'h5500_00AA, "R6 layout readback");
    idle(4); rd(3'd2, "R2 whole plus fraction");
    // R5 and R3 rollover
    wr(3'd2, 32'd999_999_990);
    rd(3'd2, "R5 ns loaded"); idle(3);
    rd(3'd2, "R3 ns wrapped"); rd(3'd0, "R3 sec carried");
    // R7 offsets around borrow and carry
    wr(3'd2, 32'd999_999_995);
    wr(3'd5, 32'h8000_0000 | 32'd999_999_000);
    rd(3'd2, "R7 subtract"); rd(3'd0, "R7 subtract sec");
    wr(3'd2, 32'd999_999_998);
    wr(3'd5, 32'd999_999_999);
    rd(3'd2, "R7 add wrap"); rd(3'd0, "R7 add carry sec");
    wr(3'd2, 32'd5);
    wr(3'd5, 32'h8000_0000 | 32'd900_000_000);
    rd(3'd2, "R7 borrow"); rd(3'd0, "R7 borrow sec");
    // R8 zero increment stops
    wr(3'd4, 32'h0); wr(3'd3, 32'h0); idle(2);
    rd(3'd2, "R8 hold a"); idle(7); rd(3'd2, "R8 hold b"); rd(3'd0, "R8 hold sec");
    // random mix
    for (int it = 0; it < 600; it++) begin
      int op;
      logic [31:0] d;
      op = int'($urandom_range(0, 11));
      case (op)
        0: wr(3'd0, $urandom());
        1: wr(3'd1, $urandom());
        2: wr(3'd2, $urandom_range(999_999_999, 0));
        3: wr(3'd3, $urandom());
        4: wr(3'd4, $urandom());
        5: begin
             d = $urandom_range(999_999_999, 0);
             d[31] = 1'($urandom_range(1, 0));
             wr(3'd5, d);
           end
        6: rd(3'd0, "R3 random sec");
        7: rd(3'd1, "R9 random shadow");
        8: rd(3'd2, "R2 random ns");
        9: rd(3'($urandom_range(7, 3)), "R10 random reg");
        default: idle(int'($urandom_range(8, 1)));
      endcase
    end
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule